// File: doc/BRIEF.md
# Wide Control Store with Sliced Readback

This block is a microcode control store. It holds 4096 words of 36 bits each, which can also be seen as 16 pages of 256 words, each page split into four 64-word quarters. The host side of the store is only 16 bits wide. A wide word is therefore filled by two write commands that share one 12-bit address. The first command delivers the low half plus a 4-bit extra nibble. The second command delivers the upper 16 bits.

Readback goes through a 16-bit registered output, one slice per read strobe. A 4-bit auxiliary latch captures one of the two odd-sized nibbles of the word on every read. A later read can then return that nibble packed above the 12-bit middle field. Two select inputs control a read. One chooses which slice appears on the output. The other chooses which nibble the latch captures. The storage is a plain synchronous array.

Top module: `wide_cstore`

## Requirements
- R1: Each of the 2^ADDR_W word addresses (4096 by default) holds its own 36-bit word; writing one address leaves every other address unchanged.
- R2: A first-write command (`wr_first`) stores `wdata` into word bits 0..15 and `wext` into bits 16..19, and leaves bits 20..35 unchanged.
- R3: A second-write command (`wr_second`) stores `wdata[11:0]` into word bits 20..31 and `wdata[15:12]` into bits 32..35, and leaves bits 0..19 unchanged.
- R4: A read strobe with `slice_upper`=0 places word bits 0..15 on `rdata` at the next rising clock edge.
- R5: A read strobe with `slice_upper`=1 places, at the next edge, `rdata[15:12]` = the auxiliary latch as it was before that edge and `rdata[11:0]` = word bits 20..31.
- R6: A read strobe with `aux_top`=0 loads the auxiliary latch from word bits 16..19, on the same edge that updates `rdata`.
- R7: A read strobe with `aux_top`=1 loads the auxiliary latch from word bits 32..35, on the same edge that updates `rdata`.
- R8: Without a read strobe, `rdata` and the auxiliary latch hold their values, including during writes.
- R9: If a read strobe coincides with either write command, the write is performed and the read is ignored: `rdata` and the latch keep their values.
- R10: A synchronous active-low reset clears `rdata` and the auxiliary latch to zero; stored words are not cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | ADDR_W (12) | Word address shared by writes and reads |
| wdata | input | DATA_W (16) | Host write data |
| wext | input | EXT_W (4) | Extra nibble stored by the first write |
| wr_first | input | 1 | First-write command: bits 0..19 |
| wr_second | input | 1 | Second-write command: bits 20..35 |
| rd_en | input | 1 | Read strobe |
| slice_upper | input | 1 | Read slice: 0 = bits 0..15, 1 = latch plus bits 20..31 |
| aux_top | input | 1 | Latch source on a read: 0 = bits 16..19, 1 = bits 32..35 |
| rdata | output | DATA_W (16) | Registered read-back slice |

## Verification
The bench builds the store with ADDR_W = 8, which gives 256 words with the field widths left at their defaults. This makes a complete fill followed by a full three-slice readback of every address cheap, so address aliasing and cross-address corruption fall within reach. The address-independent behaviour is unchanged at this size: the field packing, the latch-source choice, the old-latch value on upper reads, and the write-over-read collision. These are exercised through a vector table and directed cases.

// File: rtl/cs_pkg.sv
// Package: shared encodings for the wide control store.
// Assumes: one-bit select inputs map directly onto these enums.
package cs_pkg;

    // Which 16-bit slice a read returns
    typedef enum logic {
        SLICE_LOW   = 1'b0,
        SLICE_UPPER = 1'b1
    } slice_e;

    // Which nibble the auxiliary latch captures on a read
    typedef enum logic {
        AUX_FROM_MID_NIB = 1'b0,
        AUX_FROM_TOP_NIB = 1'b1
    } aux_src_e;

    // Qualified operations after collision resolution
    typedef struct packed {
        logic we_first;
        logic we_second;
        logic rd_go;
    } cs_op_t;

endpackage

// File: rtl/cs_op_decode.sv
// Module: cs_op_decode
// Turns raw strobes into qualified field-write and read enables.
// Assumes: a read that coincides with any write is dropped (write wins).
module cs_op_decode
    import cs_pkg::*;
(
    input  logic   wr_first,
    input  logic   wr_second,
    input  logic   rd_en,
    output cs_op_t op
);

    // Resolve write-over-read priority
    always_comb begin
        op.we_first  = wr_first;
        op.we_second = wr_second;
        op.rd_go     = rd_en & ~(wr_first | wr_second);
    end

endmodule

// File: rtl/cs_field_bank.sv
// Module: cs_field_bank
// One field of every stored word: synchronous write, combinational read at
// the same address. Assumes: no reset of contents (plain array).
module cs_field_bank #(
    parameter int WIDTH  = 16,
    parameter int ADDR_W = 12,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wdata,
    output logic [WIDTH-1:0]  rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    // Store the field on a write
    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    // Present the addressed field to the read path
    assign rdata = mem[addr];

endmodule

// File: rtl/cs_read_slice.sv
// Module: cs_read_slice
// Registered 16-bit read-back and the auxiliary nibble latch.
// Assumes: rd_go is already qualified against writes; both registers update
// on the same edge, so an upper-slice read shows the latch's prior value.
module cs_read_slice
    import cs_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int EXT_W  = 4,
    localparam int MID_W = DATA_W - EXT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_go,
    input  slice_e            slice,
    input  aux_src_e          aux_src,
    input  logic [DATA_W-1:0] f_low,
    input  logic [EXT_W-1:0]  f_nib,
    input  logic [MID_W-1:0]  f_mid,
    input  logic [EXT_W-1:0]  f_top,
    output logic [DATA_W-1:0] rdata,
    output logic [EXT_W-1:0]  aux_q
);

    logic [DATA_W-1:0] slice_d;
    logic [EXT_W-1:0]  aux_d;

    // Pick the output slice
    always_comb begin
        if (slice == SLICE_UPPER) slice_d = {aux_q, f_mid};
        else                      slice_d = f_low;
    end

    // Pick the nibble for the latch
    always_comb begin
        if (aux_src == AUX_FROM_TOP_NIB) aux_d = f_top;
        else                             aux_d = f_nib;
    end

    // Update output and latch together on a qualified read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
            aux_q <= '0;
        end else if (rd_go) begin
            rdata <= slice_d;
            aux_q <= aux_d;
        end
    end

endmodule

// File: rtl/wide_cstore.sv
// Module: wide_cstore (top)
// 2^ADDR_W words of 2*DATA_W+EXT_W bits reached through a DATA_W port.
// Word layout: [DATA_W-1:0] low, then EXT_W nibble, then MID_W middle,
// then EXT_W top. Assumes DATA_W > EXT_W.
module wide_cstore
    import cs_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16,
    parameter int EXT_W  = 4,
    localparam int MID_W = DATA_W - EXT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [EXT_W-1:0]  wext,
    input  logic              wr_first,
    input  logic              wr_second,
    input  logic              rd_en,
    input  logic              slice_upper,
    input  logic              aux_top,
    output logic [DATA_W-1:0] rdata
);

    cs_op_t            op;
    logic [DATA_W-1:0] f_low;
    logic [EXT_W-1:0]  f_nib;
    logic [MID_W-1:0]  f_mid;
    logic [EXT_W-1:0]  f_top;
    logic [EXT_W-1:0]  aux_q;

    cs_op_decode u_dec (
        .wr_first (wr_first),
        .wr_second(wr_second),
        .rd_en    (rd_en),
        .op       (op)
    );

    cs_field_bank #(.WIDTH(DATA_W), .ADDR_W(ADDR_W)) u_low (
        .clk(clk), .we(op.we_first), .addr(addr),
        .wdata(wdata), .rdata(f_low)
    );

    cs_field_bank #(.WIDTH(EXT_W), .ADDR_W(ADDR_W)) u_nib (
        .clk(clk), .we(op.we_first), .addr(addr),
        .wdata(wext), .rdata(f_nib)
    );

    cs_field_bank #(.WIDTH(MID_W), .ADDR_W(ADDR_W)) u_mid (
        .clk(clk), .we(op.we_second), .addr(addr),
        .wdata(wdata[MID_W-1:0]), .rdata(f_mid)
    );

    cs_field_bank #(.WIDTH(EXT_W), .ADDR_W(ADDR_W)) u_top (
        .clk(clk), .we(op.we_second), .addr(addr),
        .wdata(wdata[DATA_W-1:MID_W]), .rdata(f_top)
    );

    cs_read_slice #(.DATA_W(DATA_W), .EXT_W(EXT_W)) u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_go  (op.rd_go),
        .slice  (slice_e'(slice_upper)),
        .aux_src(aux_src_e'(aux_top)),
        .f_low  (f_low),
        .f_nib  (f_nib),
        .f_mid  (f_mid),
        .f_top  (f_top),
        .rdata  (rdata),
        .aux_q  (aux_q)
    );

endmodule

// File: rtl/wide_cstore_checker.sv
// Module: wide_cstore_checker
// Temporal checks on the read path, bound into wide_cstore.
// Assumes: bank read values are sampled at the strobe cycle.
module wide_cstore_checker #(
    parameter int DATA_W = 16,
    parameter int EXT_W  = 4,
    localparam int MID_W = DATA_W - EXT_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic              wr_first,
    input logic              wr_second,
    input logic              slice_upper,
    input logic              aux_top,
    input logic [DATA_W-1:0] rdata,
    input logic [EXT_W-1:0]  aux_q,
    input logic [DATA_W-1:0] f_low,
    input logic [EXT_W-1:0]  f_nib,
    input logic [MID_W-1:0]  f_mid,
    input logic [EXT_W-1:0]  f_top
);

    logic clean_rd;
    assign clean_rd = rd_en && !wr_first && !wr_second;

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (rdata == '0 && aux_q == '0)); // R10

    AST_LOW_SLICE: assert property (@(posedge clk) disable iff (!rst_n)
        (clean_rd && !slice_upper) |=> rdata == $past(f_low)); // R4

    AST_UPPER_SLICE: assert property (@(posedge clk) disable iff (!rst_n)
        (clean_rd && slice_upper) |=> rdata == {$past(aux_q), $past(f_mid)}); // R5

    AST_AUX_MID_NIB: assert property (@(posedge clk) disable iff (!rst_n)
        (clean_rd && !aux_top) |=> aux_q == $past(f_nib)); // R6

    AST_AUX_TOP_NIB: assert property (@(posedge clk) disable iff (!rst_n)
        (clean_rd && aux_top) |=> aux_q == $past(f_top)); // R7

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> ($stable(rdata) && $stable(aux_q))); // R8

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (wr_first || wr_second)) |=> ($stable(rdata) && $stable(aux_q))); // R9

endmodule

bind wide_cstore wide_cstore_checker #(.DATA_W(DATA_W), .EXT_W(EXT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .wr_first   (wr_first),
    .wr_second  (wr_second),
    .slice_upper(slice_upper),
    .aux_top    (aux_top),
    .rdata      (rdata),
    .aux_q      (aux_q),
    .f_low      (f_low),
    .f_nib      (f_nib),
    .f_mid      (f_mid),
    .f_top      (f_top)
);

// File: tb/wide_cstore_test.sv
module wide_cstore_test;

    localparam int AW = 8;
    localparam int NV = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [3:0]  wext = '0;
    logic        wr_first = 1'b0, wr_second = 1'b0, rd_en = 1'b0;
    logic        slice_upper = 1'b0, aux_top = 1'b0;
    logic [15:0] rdata;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // Vector table: {addr[8], low16, ext4, upper16}
    localparam logic [43:0] VEC [NV] = '{
        {8'h00, 16'h0000, 4'h0, 16'h0000},
        {8'hFF, 16'hFFFF, 4'hF, 16'hFFFF},
        {8'h01, 16'hA5A5, 4'h5, 16'h5A5A},
        {8'h80, 16'h1234, 4'hC, 16'hBEEF},
        {8'h40, 16'h8001, 4'h9, 16'h7FFE},
        {8'h3F, 16'hDEAD, 4'h3, 16'hC0DE},
        {8'h7E, 16'h0F0F, 4'hA, 16'hF00F},
        {8'hC1, 16'h5555, 4'h6, 16'hAAAA}
    };

    wide_cstore #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wext(wext),
        .wr_first(wr_first), .wr_second(wr_second), .rd_en(rd_en),
        .slice_upper(slice_upper), .aux_top(aux_top), .rdata(rdata)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr1(input logic [AW-1:0] a, input logic [15:0] d, input logic [3:0] x);
        @(negedge clk); addr = a; wdata = d; wext = x; wr_first = 1'b1;
        @(negedge clk); wr_first = 1'b0;
    endtask

    task automatic wr2(input logic [AW-1:0] a, input logic [15:0] d);
        @(negedge clk); addr = a; wdata = d; wr_second = 1'b1;
        @(negedge clk); wr_second = 1'b0;
    endtask

    // Read strobe for one cycle; result is valid at return
    task automatic rd(input logic [AW-1:0] a, input logic up, input logic tp);
        @(negedge clk); addr = a; slice_upper = up; aux_top = tp; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    function automatic logic [15:0] pat_lo(input int a);
        return 16'((a * 40503) ^ 16'h5A3C);
    endfunction
    function automatic logic [15:0] pat_hi(input int a);
        return 16'((a * 9973) ^ 16'hC3A1);
    endfunction
    function automatic logic [3:0] pat_x(input int a);
        return 4'((a * 7) ^ (a >> 4));
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 reset rdata", rdata, 16'h0000);
        rst_n = 1'b1;
        wr2(8'h10, 16'h0ABC);
        rd(8'h10, 1'b1, 1'b0);
        check("R10 latch cleared by reset", rdata, 16'h0ABC);

        // Table walk: R2 R3 R4 R5 R6 R7
        for (int i = 0; i < NV; i++) begin
            wr1(VEC[i][43:36], VEC[i][35:20], VEC[i][19:16]);
            wr2(VEC[i][43:36], VEC[i][15:0]);
        end
        for (int i = 0; i < NV; i++) begin
            logic [AW-1:0] a;
            a = VEC[i][43:36];
            rd(a, 1'b0, 1'b0);
            check("R4 R2 low slice", rdata, VEC[i][35:20]);
            rd(a, 1'b1, 1'b1);
            check("R5 R6 latch nib and middle", rdata, {VEC[i][19:16], VEC[i][11:0]});
            rd(a, 1'b1, 1'b0);
            check("R7 R3 latch top and middle", rdata, VEC[i][15:0]);
        end

        // R8: idle cycles and writes leave rdata and latch alone
        rd(8'h01, 1'b0, 1'b1);                 // rdata=A5A5, latch=5 (top of 5A5A)
        repeat (3) @(negedge clk);
        check("R8 idle hold", rdata, 16'hA5A5);
        wr1(8'h01, 16'h1111, 4'h2);
        wr2(8'h02, 16'h2222);
        check("R8 hold across writes", rdata, 16'hA5A5);
        rd(8'h02, 1'b1, 1'b0);
        check("R8 latch held", rdata, 16'h5222);

        // R3: second write leaves bits 0..19
        wr2(8'h01, 16'h9876);
        rd(8'h01, 1'b0, 1'b0);
        check("R3 low kept", rdata, 16'h1111);
        rd(8'h01, 1'b1, 1'b1);
        check("R3 nib kept", rdata, 16'h2876);
        // R2: first write leaves bits 20..35
        wr1(8'h01, 16'h4444, 4'hE);
        rd(8'h01, 1'b1, 1'b0);
        check("R2 top kept", rdata, 16'h9876);

        // R9: read coinciding with a write is ignored, write lands
        @(negedge clk); addr = 8'h01; wdata = 16'h7777; wext = 4'h1;
        wr_first = 1'b1; rd_en = 1'b1; slice_upper = 1'b0; aux_top = 1'b0;
        @(negedge clk); wr_first = 1'b0; rd_en = 1'b0;
        check("R9 rdata unchanged", rdata, 16'h9876);
        rd(8'h01, 1'b1, 1'b0);
        check("R9 latch unchanged", rdata, 16'hE876);
        rd(8'h01, 1'b0, 1'b0);
        check("R9 write performed", rdata, 16'h7777);

        // R1: fill every address, then read all back
        for (int a = 0; a < (1 << AW); a++) begin
            wr1(AW'(a), pat_lo(a), pat_x(a));
            wr2(AW'(a), pat_hi(a));
        end
        for (int a = 0; a < (1 << AW); a++) begin
            logic [15:0] h;
            h = pat_hi(a);
            rd(AW'(a), 1'b0, 1'b1);
            check("R1 low field", rdata, pat_lo(a));
            rd(AW'(a), 1'b1, 1'b0);
            check("R1 top via latch", rdata, h);
            rd(AW'(a), 1'b1, 1'b0);
            check("R1 nib via latch", rdata, {pat_x(a), h[11:0]});
        end

        // R10: reset mid-run clears output, keeps contents
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R10 rdata cleared", rdata, 16'h0000);
        rd(8'h05, 1'b0, 1'b0);
        check("R10 contents kept", rdata, pat_lo(5));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule